// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a synchronous pipelined static RAM. Reads and writes can follow each other with no idle cycles between them. Each command is taken on a rising clock edge. Its data moves two active edges later: write data is sampled on that edge, and read data is launched from an output register on that edge. Because reads and writes have the same latency, the data bus never needs a turnaround gap.

A command either loads a fresh external address or advances an internal two-bit beat counter. An advance produces the next of four addresses in linear or XOR-interleaved order. The host can freeze the whole pipeline with the clock enable, or deselect the device through three chip enables. Each data word is 36 bits wide, split into four 9-bit byte lanes. Lane i occupies bits [9i+8:9i], which are eight data bits and one parity bit. Data-in and data-out are separate buses. A drive flag tells the surrounding logic when the output bus would be actively driven.

Top module: `zt_sram`

## Requirements
- R1: A read loaded at an active edge (clock enable low, adv_ld low, all chip enables active, wr_n high) places the addressed word on rdata after the second following active edge. rdrive is high in that cycle when oe_n is low.
- R2: For a write loaded at an active edge, wdata is sampled at the second following active edge. A read of the same address loaded one or two edges after that write returns the new word.
- R3: During a write, lane i (wdata bits [9i+8:9i]) is stored only when bsel_n[i] is low. Lanes whose select is high keep their previous contents.
- R4: While cke_n is high, every synchronous input is ignored and every register holds its value, so rdata and rdrive do not change. This includes a command presented during the stall. The pipeline resumes where it stopped.
- R5: With adv_ld low and any chip enable inactive (sel1_n high, sel2 low or sel3_n high), no operation starts and any running burst ends. Operations already in the pipeline still complete. A later advance starts nothing.
- R6: With burst_il low, the k-th advance after a load at address A accesses A with its two low bits replaced by (A[1:0]+k) mod 4. The upper bits stay fixed.
- R7: With burst_il high, the k-th advance accesses A with its low bits replaced by A[1:0] XOR k.
- R8: An advance inherits read or write from the loading command, and wr_n is ignored on advance cycles. bsel_n is sampled fresh on every beat.
- R9: rdrive is low during the data phase of a write and during any data phase without a read, whatever oe_n is. A read may directly follow or precede a write with no idle cycle.
- R10: oe_n high forces rdrive low without delay. The read data still appears on rdata.
- R11: After reset, rdrive is low and no burst is active, so advances start nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address for a load command |
| wr_n | input | 1 | Low for write, high for read, on load cycles |
| adv_ld | input | 1 | Low loads addr, high advances the beat counter |
| sel1_n | input | 1 | Chip enable, active low |
| sel2 | input | 1 | Chip enable, active high |
| sel3_n | input | 1 | Chip enable, active low |
| cke_n | input | 1 | Clock enable, active low; high stalls the block |
| bsel_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_il | input | 1 | Burst order: 1 interleaved (XOR), 0 linear |
| wdata | input | LANES*LANE_W | Write data, sampled in the write data phase |
| rdata | output | LANES*LANE_W | Registered read data |
| rdrive | output | 1 | High when the output bus is driven |

## Verification
Each result is due exactly two active edges after the command that causes it. An edge taken with cke_n high does not count, and after such an edge the outputs must stay as they were. The driver numbers the active edges. It books every read and write to the edge number of its data phase, and on each edge it queues one expectation: a read word, an undriven bus, or unchanged outputs after a stall. The monitor samples a quarter period after every rising edge and pops exactly one expectation per edge, so a result that arrives one edge early or late is caught.

// File: rtl/zt_pkg.sv
package zt_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  // Low address bits for a given beat of a four-beat burst.
  function automatic logic [1:0] beat_low(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input order_e     ord);
    if (ord == ORD_XOR) beat_low = base ^ cnt;
    else                beat_low = base + cnt;
  endfunction

endpackage

// File: rtl/zt_cmd.sv
module zt_cmd #(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cke,
  input  logic               ld_n,
  input  logic               wr_req,
  input  logic               sel_ok,
  input  logic [AW-1:0]      addr,
  input  logic [LANES-1:0]   lane_en,
  input  zt_pkg::order_e     ord,
  output logic               s1_vld,
  output logic               s1_wr,
  output logic [AW-1:0]      s1_addr,
  output logic [LANES-1:0]   s1_be,
  output logic               b_act
);
  localparam int UW = AW - 2;

  logic          b_wr, n_act, n_wr;
  logic [UW-1:0] b_up, n_up;
  logic [1:0]    b_base, b_cnt, n_base, n_cnt, cnt_inc;
  logic          o_vld, o_wr;
  logic [AW-1:0] o_addr;
  logic [LANES-1:0] o_be;

  assign cnt_inc = b_cnt + 2'd1;

  always_comb begin
    n_act  = b_act;
    n_wr   = b_wr;
    n_up   = b_up;
    n_base = b_base;
    n_cnt  = b_cnt;
    o_vld  = 1'b0;
    o_wr   = b_wr;
    o_addr = {b_up, zt_pkg::beat_low(b_base, cnt_inc, ord)};
    if (!ld_n) begin
      if (sel_ok) begin
        n_act  = 1'b1;
        n_wr   = wr_req;
        n_up   = addr[AW-1:2];
        n_base = addr[1:0];
        n_cnt  = 2'd0;
        o_vld  = 1'b1;
        o_wr   = wr_req;
        o_addr = addr;
      end else begin
        n_act  = 1'b0;
      end
    end else if (b_act) begin
      n_cnt = cnt_inc;
      o_vld = 1'b1;
    end
    o_be = o_wr ? lane_en : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_act   <= 1'b0;
      b_wr    <= 1'b0;
      b_up    <= '0;
      b_base  <= '0;
      b_cnt   <= '0;
      s1_vld  <= 1'b0;
      s1_wr   <= 1'b0;
      s1_addr <= '0;
      s1_be   <= '0;
    end else if (cke) begin
      b_act   <= n_act;
      b_wr    <= n_wr;
      b_up    <= n_up;
      b_base  <= n_base;
      b_cnt   <= n_cnt;
      s1_vld  <= o_vld;
      s1_wr   <= o_wr;
      s1_addr <= o_addr;
      s1_be   <= o_be;
    end
  end

endmodule

// File: rtl/zt_stage.sv
module zt_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cke,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (cke) q <= d;
  end
endmodule

// File: rtl/zt_lanes.sv
module zt_lanes #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke,
  input  logic                    vld,
  input  logic                    wr,
  input  logic [AW-1:0]           addr,
  input  logic [LANES-1:0]        be,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    drv
);
  localparam int DEPTH = 1 << AW;

  logic go_wr, go_rd, drv_n;

  assign go_wr = cke & vld & wr;
  assign go_rd = cke & vld & ~wr;
  assign drv_n = vld & ~wr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (go_wr && be[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (go_rd) rd_q <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   drv <= 1'b0;
    else if (cke) drv <= drv_n;
  end

endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic                    wr_n,
  input  logic                    adv_ld,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    cke_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic                    oe_n,
  input  logic                    burst_il,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdrive
);
  localparam int DW = LANES * LANE_W;
  localparam int SW = 2 + AW + LANES;

  logic             cke, sel_ok, b_act, drv_q;
  logic             s1_vld, s1_wr, s2_vld, s2_wr;
  logic [AW-1:0]    s1_addr, s2_addr;
  logic [LANES-1:0] s1_be, s2_be;
  logic [SW-1:0]    s1_bus, s2_bus;

  assign cke    = ~cke_n;
  assign sel_ok = ~sel1_n & sel2 & ~sel3_n;

  zt_cmd #(.AW(AW), .LANES(LANES)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke     (cke),
    .ld_n    (adv_ld),
    .wr_req  (~wr_n),
    .sel_ok  (sel_ok),
    .addr    (addr),
    .lane_en (~bsel_n),
    .ord     (zt_pkg::order_e'(burst_il)),
    .s1_vld  (s1_vld),
    .s1_wr   (s1_wr),
    .s1_addr (s1_addr),
    .s1_be   (s1_be),
    .b_act   (b_act)
  );

  assign s1_bus = {s1_vld, s1_wr, s1_addr, s1_be};

  zt_stage #(.W(SW)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .d     (s1_bus),
    .q     (s2_bus)
  );

  assign {s2_vld, s2_wr, s2_addr, s2_be} = s2_bus;

  zt_lanes #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .vld   (s2_vld),
    .wr    (s2_wr),
    .addr  (s2_addr),
    .be    (s2_be),
    .wdata (wdata),
    .rdata (rdata),
    .drv   (drv_q)
  );

  assign rdrive = drv_q & ~oe_n;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke_n,
  input logic          adv_ld,
  input logic          sel1_n,
  input logic          sel2,
  input logic          sel3_n,
  input logic          oe_n,
  input logic          rdrive,
  input logic [DW-1:0] rdata,
  input logic          s1_vld,
  input logic          s2_vld,
  input logic          s2_wr,
  input logic          b_act
);
  logic pins_sel;
  assign pins_sel = !sel1_n && sel2 && !sel3_n;

  // R4: a stalled edge leaves the read register untouched
  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(rdata));

  // R10: the bus is never driven while output enable is inactive
  a_r10_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
    rdrive |-> !oe_n);

  // R5: a load with a chip enable inactive starts nothing
  a_r5_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld && !pins_sel) |=> !s1_vld);

  // R9: the data phase of a write never drives the bus
  a_r9_write_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && s2_vld && s2_wr) |=> !rdrive);

  // R11: an advance without an open burst starts nothing
  a_r11_orphan_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv_ld && !b_act) |=> !s1_vld);

endmodule

bind zt_sram zt_sram_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cke_n  (cke_n),
  .adv_ld (adv_ld),
  .sel1_n (sel1_n),
  .sel2   (sel2),
  .sel3_n (sel3_n),
  .oe_n   (oe_n),
  .rdrive (rdrive),
  .rdata  (rdata),
  .s1_vld (s1_vld),
  .s2_vld (s2_vld),
  .s2_wr  (s2_wr),
  .b_act  (b_act)
);

// File: tb/zt_sram_test.sv
module zt_sram_test;
  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int DW    = 36;

  logic          clk, rst_n;
  logic [AW-1:0] addr;
  logic          wr_n, adv_ld, sel1_n, sel2, sel3_n, cke_n, oe_n, burst_il;
  logic [3:0]    bsel_n;
  logic [DW-1:0] wdata, rdata;
  logic          rdrive;

  zt_sram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_n(wr_n), .adv_ld(adv_ld),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .cke_n(cke_n),
    .bsel_n(bsel_n), .oe_n(oe_n), .burst_il(burst_il), .wdata(wdata),
    .rdata(rdata), .rdrive(rdrive)
  );

  typedef struct {
    int          due;
    bit          wr;
    int          a;
    logic [3:0]  be;
    logic [35:0] d;
    string       req;
  } op_t;

  // kind 0: bus undriven, 1: read word, 2: outputs unchanged
  typedef struct {
    int          kind;
    logic [35:0] v;
    string       req;
  } ex_t;

  op_t         pq[$];
  ex_t         sbq[$];
  logic [35:0] mm [64];
  int          k = 0, salt = 1, checks = 0, errors = 0;
  bit          b_act = 0, b_wr = 0;
  int          b_base = 0, b_up = 0, b_cnt = 0;
  logic [35:0] last_d;
  logic        last_v;

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  function automatic logic [35:0] mk(input int s);
    return {4'(s), 32'(s * 32'h9E3779B1 + 32'h0000_1234)};
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    report();
  end

  // Monitor: one expectation per rising edge, sampled a quarter period later
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (sbq.size() > 0) begin
        ex_t e;
        e = sbq.pop_front();
        checks++;
        case (e.kind)
          0: if (rdrive !== 1'b0) begin
               errors++;
               $display("FAIL %s: rdrive actual=%b expected=0", e.req, rdrive);
             end
          1: if (rdata !== e.v || rdrive !== !oe_n) begin
               errors++;
               $display("FAIL %s: rdata actual=%h expected=%h rdrive actual=%b expected=%b",
                        e.req, rdata, e.v, rdrive, !oe_n);
             end
          default: if (rdata !== last_d || rdrive !== last_v) begin
               errors++;
               $display("FAIL %s: stall changed outputs rdata actual=%h expected=%h rdrive actual=%b expected=%b",
                        e.req, rdata, last_d, rdrive, last_v);
             end
        endcase
      end
      last_d = rdata;
      last_v = rdrive;
    end
  end

  // Driver: starts and ends at a falling edge; adv=1 advances, en=0 deselects
  task automatic cyc(input bit adv, input bit wr, input int a, input bit en,
                     input logic [3:0] ben, input bit stall, input string req);
    adv_ld = adv;
    wr_n   = !wr;
    addr   = AW'(a);
    sel1_n = !en;
    sel2   = en;
    sel3_n = !en;
    bsel_n = ben;
    cke_n  = stall;
    wdata  = '0;
    foreach (pq[i]) if (pq[i].due == k + 1 && pq[i].wr) wdata = pq[i].d;
    @(posedge clk);
    if (stall) begin
      sbq.push_back('{2, '0, req});
    end else begin
      ex_t e;
      bit  go;
      op_t o;
      k++;
      e = '{0, '0, req};
      if (pq.size() > 0 && pq[0].due == k) begin
        op_t p;
        p = pq.pop_front();
        if (p.wr) begin
          for (int i = 0; i < 4; i++) if (p.be[i]) mm[p.a][i*9 +: 9] = p.d[i*9 +: 9];
          e = '{0, '0, p.req};
        end else begin
          e = '{1, mm[p.a], p.req};
        end
      end
      sbq.push_back(e);
      go = 0;
      o.a = 0;
      if (!adv) begin
        if (en) begin
          b_act = 1; b_wr = wr; b_base = a & 3; b_up = a >> 2; b_cnt = 0;
          go = 1; o.a = a;
        end else begin
          b_act = 0;
        end
      end else if (b_act) begin
        b_cnt = (b_cnt + 1) & 3;
        o.a = b_up * 4 + (burst_il ? (b_base ^ b_cnt) : ((b_base + b_cnt) & 3));
        go = 1;
      end
      if (go) begin
        o.due = k + 2;
        o.wr  = b_wr;
        o.be  = b_wr ? ~ben : 4'h0;
        o.d   = mk(salt);
        o.req = req;
        salt++;
        pq.push_back(o);
      end
    end
    @(negedge clk);
  endtask

  task automatic load(input bit wr, input int a, input string req);
    cyc(0, wr, a, 1, 4'h0, 0, req);
  endtask

  task automatic adv_c(input logic [3:0] ben, input string req);
    cyc(1, 0, 0, 1, ben, 0, req);
  endtask

  task automatic idle(input string req);
    cyc(0, 0, 0, 0, 4'h0, 0, req);
  endtask

  initial begin
    rst_n = 0; adv_ld = 0; wr_n = 1; addr = '0; sel1_n = 1; sel2 = 0; sel3_n = 1;
    cke_n = 0; bsel_n = '0; oe_n = 0; burst_il = 0; wdata = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (rdrive !== 1'b0) begin
      errors++;
      $display("FAIL R11: rdrive in reset actual=%b expected=0", rdrive);
    end
    rst_n = 1;
    adv_c(4'h0, "R11");
    adv_c(4'h0, "R11");
    idle("R11");

    for (int a = 0; a < 32; a++) load(1, a, "R2");
    for (int a = 0; a < 4; a++) load(0, a, "R1");

    // R2: read right after a write, and one idle edge after a write
    load(1, 20, "R2");
    load(0, 20, "R2");
    load(1, 21, "R2");
    idle("R2");
    load(0, 21, "R2");

    // R9: alternating reads and writes with no gap
    load(0, 0, "R9");
    load(1, 1, "R9");
    load(0, 1, "R9");
    load(1, 2, "R9");
    load(0, 2, "R9");

    // R3: selects 1010 store lanes 0 and 2 only
    cyc(0, 1, 3, 1, 4'b1010, 0, "R3");
    load(0, 3, "R3");

    // R4: stall with a write of address 5 presented, which must be dropped
    load(0, 1, "R4");
    cyc(0, 1, 5, 1, 4'h0, 1, "R4");
    cyc(0, 1, 5, 1, 4'h0, 1, "R4");
    idle("R4");
    idle("R4");
    load(0, 5, "R4");

    // R5: deselect lets the pending read finish; bursts stop
    load(0, 2, "R5");
    idle("R5");
    adv_c(4'h0, "R5");
    idle("R5");
    load(0, 8, "R5");
    adv_c(4'h0, "R5");
    idle("R5");
    adv_c(4'h0, "R5");
    idle("R5");
    idle("R5");

    // R8 + R6: linear write burst from 25 (25,26,27,24), wr_n high on advances
    burst_il = 0;
    load(1, 25, "R8");
    adv_c(4'h0, "R8");
    adv_c(4'h0, "R8");
    adv_c(4'b1100, "R8");
    load(0, 25, "R6");
    adv_c(4'h0, "R6");
    adv_c(4'h0, "R6");
    adv_c(4'h0, "R6");
    idle("R6");
    idle("R6");

    // R7: interleaved read burst from 25 (25,24,27,26)
    burst_il = 1;
    load(0, 25, "R7");
    adv_c(4'h0, "R7");
    adv_c(4'h0, "R7");
    adv_c(4'h0, "R7");
    adv_c(4'h0, "R7");
    idle("R7");
    idle("R7");

    // R10: output enable high during a read data phase
    load(0, 4, "R10");
    idle("R10");
    oe_n = 1;
    idle("R10");
    oe_n = 0;
    load(0, 6, "R10");
    idle("R10");
    idle("R10");
    idle("R10");

    #(CLK_P);
    report();
  end

endmodule